// File: doc/BRIEF.md
# System-to-Peripheral Bridge with Posted Writes

This block takes single requests from a simple system-side port and turns each one into an APB transfer. The system-side port uses a valid/ready handshake. A request carries an address, a write flag, write data and a posted flag. Only one request is in flight at a time. A new request waits (ready low) until the APB transfer of the previous one has finished, so requests reach the peripheral in the order they were accepted.

The peripheral side does not have a clock of its own. It advances only on cycles where an internal strobe, `pclk_en`, is high. The strobe fires once every `RATIO` system cycles, and the strobe is also driven out so that slaves can use the same enable.

The response differs by kind of request:
- A read is blocking. Its response, carrying the read data and an error bit, comes back one system cycle after the APB access completes.
- A non-posted write is blocking in the same way.
- A posted write is acknowledged on the cycle after it is accepted. Its APB transfer then drains on its own.
- An error reported by the slave on a posted write has no response to travel on, so it is kept in a sticky flag.

Top module: `sys2per_bridge`

## Requirements
- R1: `pclk_en` is high for exactly one system cycle in every `RATIO` cycles. `psel` and `penable` change only at clock edges that end a cycle in which `pclk_en` was high.
- R2: Each transfer spends exactly one strobe cycle in SETUP (`psel`=1, `penable`=0). It then stays in ACCESS (`psel`=1, `penable`=1) until `pready` is sampled high on a strobe cycle. A slave that adds N wait states therefore costs 2+N strobe cycles.
- R3: `paddr`, `pwrite` and `pwdata` hold steady from SETUP to the end of ACCESS. `psel` and `penable` are both low in the cycle after the completing ACCESS cycle.
- R4: For a read (`req_write`=0), `rsp_valid` is a one-cycle pulse in the system cycle right after the completing ACCESS cycle. `rsp_rdata` equals the `prdata` the slave gave at completion. No response appears while ACCESS is in progress.
- R5: A non-posted write (`req_write`=1, `req_posted`=0) answers with the same timing as a read, and `rsp_rdata` is zero.
- R6: A posted write (`req_write`=1, `req_posted`=1) gets a one-cycle `rsp_valid` pulse, with `rsp_err`=0, in the cycle after acceptance. This happens before its APB SETUP begins.
- R7: `req_ready` is low from the acceptance of a request until its APB transfer completes. This covers a posted write that is still draining. A later request therefore never reaches the APB before an earlier one has finished.
- R8: For reads and non-posted writes, `rsp_err` carries the `pslverr` value sampled at completion.
- R9: `pslverr` at the completion of a posted write sets `post_err`. The flag then stays high until reset. Errors on blocking requests do not touch it.
- R10: During reset, `psel`, `penable`, `rsp_valid` and `post_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request this cycle |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_posted | input | 1 | For writes: 1 = acknowledge on buffering |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DW | Read data (zero for writes) |
| rsp_err | output | 1 | Slave error for blocking requests |
| post_err | output | 1 | Sticky error from a posted write |
| pclk_en | output | 1 | Peripheral-side advance strobe |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (ACCESS phase) |
| paddr | output | AW | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DW | APB write data |
| prdata | input | DW | APB read data |
| pready | input | 1 | APB slave ready |
| pslverr | input | 1 | APB slave error |

## Verification
The bench's slave derives its wait-state count (0 to 3) from two address bits, and it flags an error on one word index. Each of these corner cases catches a specific fault:
- Wait-state counts across that range catch a sequencer that samples `pready` outside a strobe cycle; such a design ends ACCESS early or late.
- A posted write followed at once by a read of the same word catches a bridge that lets the read overtake the draining write; that bridge returns stale data.
- An error on a posted write, compared with errors on blocking requests, catches a design that drops the error or reports it through the wrong path.
- The response cycle is checked against the observed completion cycle. This catches both a bridge that answers during ACCESS and one that adds an extra cycle of delay.

// File: rtl/sys2per_pkg.sv
package sys2per_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } apb_phase_e;

   typedef enum logic [1:0] {
      K_READ    = 2'd0,
      K_WR_WAIT = 2'd1,
      K_WR_POST = 2'd2
   } req_kind_e;

   function automatic req_kind_e classify(input logic is_write, input logic is_posted);
      if (!is_write)     return K_READ;
      else if (is_posted) return K_WR_POST;
      else               return K_WR_WAIT;
   endfunction

endpackage

// File: rtl/sys2per_tick.sv
module sys2per_tick #(
   parameter int unsigned RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (RATIO == 1) begin : g_full_rate
         assign tick_o = 1'b1;
      end else begin : g_divided
         localparam int unsigned CW = $clog2(RATIO);
         localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sys2per_slot.sv
module sys2per_slot
   import sys2per_pkg::*;
#(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid_i,
   input  logic          req_write_i,
   input  logic          req_posted_i,
   input  logic [AW-1:0] req_addr_i,
   input  logic [DW-1:0] req_wdata_i,
   input  logic          release_i,
   output logic          req_ready_o,
   output logic          accept_o,
   output logic          full_o,
   output req_kind_e     kind_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o
);
   logic          full_q;
   req_kind_e     kind_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;

   assign accept_o    = req_valid_i & ~full_q;
   assign req_ready_o = ~full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         kind_q  <= K_READ;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept_o) begin
         full_q  <= 1'b1;
         kind_q  <= classify(req_write_i, req_posted_i);
         addr_q  <= req_addr_i;
         wdata_q <= req_write_i ? req_wdata_i : '0;
      end else if (release_i) begin
         full_q  <= 1'b0;
      end
   end

   assign full_o  = full_q;
   assign kind_o  = kind_q;
   assign addr_o  = addr_q;
   assign wdata_o = wdata_q;
endmodule

// File: rtl/sys2per_seq.sv
module sys2per_seq
   import sys2per_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic pending_i,
   input  logic pready_i,
   output logic psel_o,
   output logic penable_o,
   output logic done_o
);
   apb_phase_e phase_q, phase_d;

   assign done_o = (phase_q == PH_ACCESS) && tick_i && pready_i;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (tick_i && pending_i) phase_d = PH_SETUP;
         PH_SETUP:  if (tick_i)              phase_d = PH_ACCESS;
         PH_ACCESS: if (done_o)              phase_d = PH_IDLE;
         default:                            phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign psel_o    = (phase_q != PH_IDLE);
   assign penable_o = (phase_q == PH_ACCESS);
endmodule

// File: rtl/sys2per_resp.sv
module sys2per_resp
   import sys2per_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  logic          req_write_i,
   input  logic          req_posted_i,
   input  logic          done_i,
   input  req_kind_e     kind_i,
   input  logic [DW-1:0] prdata_i,
   input  logic          pslverr_i,
   output logic          rsp_valid_o,
   output logic [DW-1:0] rsp_rdata_o,
   output logic          rsp_err_o,
   output logic          post_err_o
);
   logic          valid_q, err_q, sticky_q;
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         rdata_q  <= '0;
         err_q    <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (accept_i && req_write_i && req_posted_i) begin
            valid_q <= 1'b1;
            rdata_q <= '0;
            err_q   <= 1'b0;
         end else if (done_i && kind_i != K_WR_POST) begin
            valid_q <= 1'b1;
            rdata_q <= (kind_i == K_READ) ? prdata_i : '0;
            err_q   <= pslverr_i;
         end
         if (done_i && kind_i == K_WR_POST && pslverr_i) sticky_q <= 1'b1;
      end
   end

   assign rsp_valid_o = valid_q;
   assign rsp_rdata_o = rdata_q;
   assign rsp_err_o   = err_q;
   assign post_err_o  = sticky_q;
endmodule

// File: rtl/sys2per_bridge.sv
module sys2per_bridge
   import sys2per_pkg::*;
#(
   parameter int unsigned AW    = 12,
   parameter int unsigned DW    = 32,
   parameter int unsigned RATIO = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic [DW-1:0] req_wdata,
   input  logic          req_posted,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_err,
   output logic          post_err,
   output logic          pclk_en,
   output logic          psel,
   output logic          penable,
   output logic [AW-1:0] paddr,
   output logic          pwrite,
   output logic [DW-1:0] pwdata,
   input  logic [DW-1:0] prdata,
   input  logic          pready,
   input  logic          pslverr
);
   initial begin
      assert (RATIO >= 1) else $fatal(1, "RATIO must be at least 1");
      assert (AW >= 2)    else $fatal(1, "AW must be at least 2");
      assert (DW >= 8 && (DW % 8) == 0) else $fatal(1, "DW must be a whole number of bytes");
   end

   logic      accept, full, done;
   req_kind_e kind;

   sys2per_tick #(.RATIO(RATIO)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (pclk_en)
   );

   sys2per_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid),
      .req_write_i  (req_write),
      .req_posted_i (req_posted),
      .req_addr_i   (req_addr),
      .req_wdata_i  (req_wdata),
      .release_i    (done),
      .req_ready_o  (req_ready),
      .accept_o     (accept),
      .full_o       (full),
      .kind_o       (kind),
      .addr_o       (paddr),
      .wdata_o      (pwdata)
   );

   sys2per_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (pclk_en),
      .pending_i (full),
      .pready_i  (pready),
      .psel_o    (psel),
      .penable_o (penable),
      .done_o    (done)
   );

   sys2per_resp #(.DW(DW)) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept_i     (accept),
      .req_write_i  (req_write),
      .req_posted_i (req_posted),
      .done_i       (done),
      .kind_i       (kind),
      .prdata_i     (prdata),
      .pslverr_i    (pslverr),
      .rsp_valid_o  (rsp_valid),
      .rsp_rdata_o  (rsp_rdata),
      .rsp_err_o    (rsp_err),
      .post_err_o   (post_err)
   );

   assign pwrite = (kind != K_READ);
endmodule

// File: rtl/sys2per_bridge_chk.sv
module sys2per_bridge_chk #(
   parameter int unsigned AW    = 12,
   parameter int unsigned DW    = 32,
   parameter int unsigned RATIO = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          post_err,
   input logic          pclk_en,
   input logic          psel,
   input logic          penable,
   input logic [AW-1:0] paddr,
   input logic          pwrite,
   input logic [DW-1:0] pwdata,
   input logic          pready
);
   int unsigned gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else if (pclk_en) begin
         gap_q  <= 0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1;
      end
   end

   AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (pclk_en && seen_q) |-> (gap_q == RATIO - 1)); // R1
   AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (gap_q < RATIO)); // R1
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pclk_en) |-> (psel == $past(psel) && penable == $past(penable))); // R1
   AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable && pclk_en) |=> (psel && penable)); // R2
   AST_ENABLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> psel); // R2
   AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable) |-> (paddr == $past(paddr) && pwrite == $past(pwrite)
                             && pwdata == $past(pwdata))); // R3
   AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && pclk_en) |=> (!psel && !penable)); // R3
   AST_NO_RSP_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable) |-> !rsp_valid); // R4
   AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R6
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      psel |-> !req_ready); // R7
   AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(post_err) |-> post_err); // R9
endmodule

bind sys2per_bridge sys2per_bridge_chk #(.AW(AW), .DW(DW), .RATIO(RATIO)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .post_err  (post_err),
   .pclk_en   (pclk_en),
   .psel      (psel),
   .penable   (penable),
   .paddr     (paddr),
   .pwrite    (pwrite),
   .pwdata    (pwdata),
   .pready    (pready)
);

// File: tb/test_sys2per_bridge.sv
module test_sys2per_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int RATIO = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_posted = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid, rsp_err, post_err, pclk_en;
   logic [DW-1:0] rsp_rdata, pwdata, prdata;
   logic          psel, penable, pwrite, pready, pslverr;
   logic [AW-1:0] paddr;

   sys2per_bridge #(.AW(AW), .DW(DW), .RATIO(RATIO)) i_sys2per_bridge (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .req_posted(req_posted), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .post_err(post_err), .pclk_en(pclk_en), .psel(psel),
      .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
      .prdata(prdata), .pready(pready), .pslverr(pslverr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- slave model: waits from addr[3:2], error on word 15
   function automatic int waits_of(input logic [AW-1:0] a);
      return int'(a[3:2]);
   endfunction
   function automatic bit err_of(input logic [AW-1:0] a);
      return (a[5:2] == 4'hF);
   endfunction
   function automatic logic [DW-1:0] init_of(input int i);
      return 32'hA500_0000 + DW'(i) * 32'h0001_0203;
   endfunction

   logic [DW-1:0] smem [16];
   logic [DW-1:0] ref_mem [16];
   int wcnt = 0;

   initial begin
      for (int i = 0; i < 16; i++) begin
         smem[i]    = init_of(i);
         ref_mem[i] = init_of(i);
      end
   end

   assign pready  = psel && penable && (wcnt == waits_of(paddr));
   assign prdata  = smem[paddr[5:2]];
   assign pslverr = pready && err_of(paddr);

   always @(posedge clk) begin
      if (pclk_en && psel && penable) begin
         if (pready) begin
            wcnt <= 0;
            if (pwrite && !pslverr) smem[paddr[5:2]] <= pwdata;
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   // ---------------- monitor, sampled at the falling edge
   bit            mon_on = 1'b0;
   int            cyc = 0, last_tick = -1, setups = 0, accs = 0;
   int            done_cyc = -100, n_done = 0, n_acc = 0;
   logic          prev_psel = 1'b0, prev_pen = 1'b0, prev_tick = 1'b1;
   bit            was_done = 1'b0;
   logic [AW-1:0] s_addr = '0;
   logic          s_wr = 1'b0;
   logic [DW-1:0] s_wd = '0;

   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (pclk_en) begin
            if (last_tick >= 0)
               chk(cyc - last_tick == RATIO, "R1 strobe spacing", longint'(cyc - last_tick), longint'(RATIO));
            last_tick = cyc;
         end
         if (!prev_tick)
            chk(psel == prev_psel && penable == prev_pen, "R1 phase moved off strobe",
                longint'({psel, penable}), longint'({prev_psel, prev_pen}));
         if (was_done) begin
            chk(!psel && !penable, "R3 select released after completion", longint'({psel, penable}), 0);
            was_done = 1'b0;
         end
         if (psel && !penable && pclk_en) begin
            setups++;
            s_addr = paddr; s_wr = pwrite; s_wd = pwdata;
         end
         if (psel && penable)
            chk(paddr == s_addr && pwrite == s_wr && pwdata == s_wd, "R3 address/data stable",
                longint'(paddr), longint'(s_addr));
         if (psel && penable && pclk_en) begin
            accs++;
            if (pready) begin
               chk(setups == 1, "R2 one setup strobe", longint'(setups), 1);
               chk(accs == waits_of(paddr) + 1, "R2 access strobes 1+N", longint'(accs),
                   longint'(waits_of(paddr) + 1));
               done_cyc = cyc;
               n_done++;
               setups = 0; accs = 0;
               was_done = 1'b1;
            end
         end
         prev_psel = psel; prev_pen = penable; prev_tick = pclk_en;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic issue(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d, input bit posted);
      int idx;
      logic [DW-1:0] exp;
      bit e;
      int guard;
      idx = int'(a[5:2]);
      exp = ref_mem[idx];
      e   = err_of(a);
      if (wr && !e) ref_mem[idx] = d;
      req_addr = a; req_write = wr; req_wdata = d; req_posted = posted; req_valid = 1'b1;
      guard = 0;
      while (!req_ready && guard < 5000) begin step(); guard++; end
      chk(n_done == n_acc, "R7 earlier transfer done before accept", longint'(n_done), longint'(n_acc));
      n_acc++;
      step();
      req_valid = 1'b0;
      if (wr && posted) begin
         chk(rsp_valid && !rsp_err, "R6 posted ack in cycle after accept", longint'({rsp_valid, rsp_err}), 2);
         chk(!psel, "R6 ack precedes APB setup", longint'(psel), 0);
         chk(!req_ready, "R7 ready low while posted write drains", longint'(req_ready), 0);
         step();
         chk(!rsp_valid, "R6 single ack pulse", longint'(rsp_valid), 0);
      end else begin
         guard = 0;
         while (!rsp_valid && guard < 5000) begin step(); guard++; end
         chk(done_cyc == cyc - 1, wr ? "R5 write ack after completion" : "R4 read rsp after completion",
             longint'(cyc - done_cyc), 1);
         chk(rsp_rdata == (wr ? '0 : exp), wr ? "R5 zero data on write" : "R4 read data",
             longint'(rsp_rdata), longint'(wr ? '0 : exp));
         chk(rsp_err == e, "R8 error forwarded", longint'(rsp_err), longint'(e));
         step();
         chk(!rsp_valid, "R4 single response pulse", longint'(rsp_valid), 0);
      end
   endtask

   task automatic drain();
      int guard = 0;
      while (n_done != n_acc && guard < 5000) begin step(); guard++; end
      step();
   endtask

   function automatic logic [AW-1:0] word(input int i);
      return AW'(i * 4);
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stimulus
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      repeat (3) step();
      chk(!psel && !penable && !rsp_valid && !post_err && req_ready, "R10 reset state",
          longint'({psel, penable, rsp_valid, post_err, req_ready}), 1);
      rst_n = 1'b1;
      mon_on = 1'b1;
      step();

      // blocking reads with 0, 3 and 1 wait states
      issue(word(0), 1'b0, '0, 1'b0);
      issue(word(3), 1'b0, '0, 1'b0);
      issue(word(5), 1'b0, '0, 1'b0);
      // non-posted write then read back
      issue(word(2), 1'b1, 32'h1234_5678, 1'b0);
      issue(word(2), 1'b0, '0, 1'b0);
      // posted write followed at once by a read of the same word (ordering)
      issue(word(7), 1'b1, 32'hCAFE_0007, 1'b1);
      issue(word(7), 1'b0, '0, 1'b0);
      // two posted writes back to back, then read both
      issue(word(4), 1'b1, 32'h0BAD_0004, 1'b1);
      issue(word(11), 1'b1, 32'h0BAD_000B, 1'b1);
      issue(word(4), 1'b0, '0, 1'b0);
      issue(word(11), 1'b0, '0, 1'b0);
      // errors on blocking requests leave the sticky flag clear
      issue(word(15), 1'b0, '0, 1'b0);
      issue(word(15), 1'b1, 32'hDEAD_BEEF, 1'b0);
      chk(!post_err, "R9 sticky untouched by blocking errors", longint'(post_err), 0);
      // posted write error sets sticky flag
      issue(word(15), 1'b1, 32'hDEAD_0000, 1'b1);
      drain();
      chk(post_err, "R9 posted error sets sticky flag", longint'(post_err), 1);
      issue(word(1), 1'b0, '0, 1'b0);
      chk(post_err, "R9 sticky flag holds", longint'(post_err), 1);

      // constrained random mix
      for (int n = 0; n < 250; n++) begin
         logic [AW-1:0] a;
         a = AW'($urandom());
         a[1:0] = 2'b00;
         issue(a, 1'($urandom() % 2), $urandom(), 1'($urandom() % 2));
      end
      drain();
      chk(post_err, "R9 sticky flag holds to the end", longint'(post_err), 1);
      chk(n_done == n_acc, "R7 every accepted request completed", longint'(n_done), longint'(n_acc));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule